// File: doc/BRIEF.md
# Conflict-Sorting Gather Unit for a Banked Array

This block takes a vector of word addresses, one per lane, and reads them from a memory split into several banks. Each bank can serve one read per cycle. Every cycle the unit forms a group of reads that uses each bank at most once and issues that group. It keeps doing so until every lane has its data. When two lanes of one bank want different words, their reads go out in different cycles. No extra port is used to serve them together.

A request is accepted while `busy` is low. Each bank has its own read port: an enable, a row address and a data return. The banks answer one cycle after the enable. When the last data is back, the unit gives a one-cycle `done` pulse. At the same time it presents the assembled vector and the number of issue cycles that were needed.

Top module: `gs_gather_sched`

## Requirements
- R1: The bank of a lane is the low log2(NBANKS) bits of its word address, and the row sent on that bank's port is the address shifted right by those bits. With four banks, bits [1:0] select the bank and bits [AW-1:2] form the row.
- R2: In any cycle each bank receives at most one read. Lanes that map to different banks are read in the same cycle, so a request that spans all banks with no conflict completes in a single issue cycle.
- R3: In every issue cycle each bank serves the lowest-numbered lane that is still pending and maps to it.
- R4: Distinct addresses in the same bank are served in successive cycles, one per cycle. A request whose 16 lanes hold 16 distinct addresses of one bank needs 16 issue cycles.
- R5: All pending lanes that hold the same address as the lane a bank serves are completed by that single read.
- R6: Read data arrives one cycle after the bank enable and is written into the result slot of every lane the read served.
- R7: `done` is high for exactly one cycle, two cycles after the last issue cycle. In that cycle `cycles` equals the number of issue cycles and `result` holds the data of every lane.
- R8: A request offered while `busy` is high is ignored: it does not alter the result or start another gather.
- R9: After reset `busy`, `done` and all bank enables are low, and `cycles` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | LANES*AW | Word address per lane, lane 0 in the low bits |
| busy | output | 1 | A gather is in progress |
| bank_re | output | NBANKS | Read enable per bank |
| bank_row | output | NBANKS*RW | Row address per bank |
| bank_rdata | input | NBANKS*DW | Data per bank, one cycle after its enable |
| done | output | 1 | One-cycle pulse when the vector is complete |
| result | output | LANES*DW | Assembled vector, lane 0 in the low bits |
| cycles | output | CW | Issue cycles used by the last gather |

## Verification
The hardest case to reach from the ports is a bank queue with mixed content: repeated addresses are interleaved with distinct ones, and the lowest pending lane changes after each cycle. In that case merging, lane order and serialization all act at once. The stimulus builds this case on purpose. Lanes are drawn from a small address pool so that duplicates are frequent. Reversed and single-bank orderings are added, and the request strobe is held high with other addresses through a whole gather to cover R8. A behavioural model computes the bucket for every cycle, and the per-bank outputs are compared against it on each clock.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } gs_state_t;
endpackage

// File: rtl/gs_bank_pick.sv
module gs_bank_pick #(
  parameter int LANES  = 16,
  parameter int NBANKS = 4,
  parameter int AW     = 8,
  parameter int BANK   = 0
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*AW-1:0] lane_addr,
  output logic                grant,
  output logic [AW-1:0]       win_addr,
  output logic [LANES-1:0]    serve
);
  localparam int BW = $clog2(NBANKS);

  logic [LANES-1:0] hit;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      hit[i] = pending[i] && (lane_addr[i*AW +: BW] == BW'(BANK));
    end
  end

  // scan from the top down so the lowest matching lane is the last to win
  always_comb begin
    grant    = 1'b0;
    win_addr = '0;
    for (int i = LANES-1; i >= 0; i--) begin
      if (hit[i]) begin
        grant    = 1'b1;
        win_addr = lane_addr[i*AW +: AW];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      serve[i] = hit[i] && (lane_addr[i*AW +: AW] == win_addr);
    end
  end
endmodule

// File: rtl/gs_resp_steer.sv
module gs_resp_steer #(
  parameter int LANES  = 16,
  parameter int NBANKS = 4,
  parameter int AW     = 8,
  parameter int DW     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES-1:0]     resp_mask,
  input  logic [LANES*AW-1:0]  lane_addr,
  input  logic [NBANKS*DW-1:0] bank_rdata,
  output logic [LANES*DW-1:0]  result
);
  localparam int BW = $clog2(NBANKS);

  logic [DW-1:0] rd_b  [NBANKS];
  logic [DW-1:0] res_q [LANES];

  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_split
      assign rd_b[b] = bank_rdata[b*DW +: DW];
    end
    for (genvar l = 0; l < LANES; l++) begin : g_pack
      assign result[l*DW +: DW] = res_q[l];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LANES; l++) res_q[l] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (resp_mask[l]) res_q[l] <= rd_b[lane_addr[l*AW +: BW]];
      end
    end
  end
endmodule

// File: rtl/gs_gather_sched.sv
module gs_gather_sched #(
  parameter int LANES  = 16,
  parameter int NBANKS = 4,
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int BW     = $clog2(NBANKS),
  parameter int RW     = AW - BW,
  parameter int CW     = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [LANES*AW-1:0]  req_addr,
  output logic                 busy,
  output logic [NBANKS-1:0]    bank_re,
  output logic [NBANKS*RW-1:0] bank_row,
  input  logic [NBANKS*DW-1:0] bank_rdata,
  output logic                 done,
  output logic [LANES*DW-1:0]  result,
  output logic [CW-1:0]        cycles
);
  import gs_pkg::*;

  gs_state_t         state_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]  pending_q;
  logic [LANES-1:0]  resp_q;
  logic [CW-1:0]     issue_cnt_q;
  logic [CW-1:0]     cycles_q;
  logic              done_q;

  logic [LANES-1:0]  serve_b [NBANKS];
  logic [AW-1:0]     win_b   [NBANKS];
  logic [LANES-1:0]  served_all;
  logic [LANES-1:0]  pending_nx;

  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      gs_bank_pick #(
        .LANES(LANES), .NBANKS(NBANKS), .AW(AW), .BANK(b)
      ) u_pick (
        .pending  (pending_q),
        .lane_addr(addr_q),
        .grant    (bank_re[b]),
        .win_addr (win_b[b]),
        .serve    (serve_b[b])
      );
      assign bank_row[b*RW +: RW] = win_b[b][AW-1:BW];
    end
  endgenerate

  always_comb begin
    served_all = '0;
    for (int b = 0; b < NBANKS; b++) served_all = served_all | serve_b[b];
    pending_nx = pending_q & ~served_all;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      pending_q   <= '0;
      resp_q      <= '0;
      issue_cnt_q <= '0;
      cycles_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      resp_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q      <= req_addr;
            pending_q   <= '1;
            issue_cnt_q <= '0;
            state_q     <= ST_RUN;
          end
        end
        ST_RUN: begin
          resp_q      <= served_all;
          pending_q   <= pending_nx;
          issue_cnt_q <= issue_cnt_q + 1'b1;
          if (pending_nx == '0) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          done_q   <= 1'b1;
          cycles_q <= issue_cnt_q;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  gs_resp_steer #(
    .LANES(LANES), .NBANKS(NBANKS), .AW(AW), .DW(DW)
  ) u_steer (
    .clk       (clk),
    .rst       (rst),
    .resp_mask (resp_q),
    .lane_addr (addr_q),
    .bank_rdata(bank_rdata),
    .result    (result)
  );

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign cycles = cycles_q;
endmodule

// File: rtl/gs_gather_sched_chk.sv
module gs_gather_sched_chk #(
  parameter int LANES  = 16,
  parameter int NBANKS = 4,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic [NBANKS-1:0] bank_re,
  input logic              done,
  input logic [CW-1:0]     cycles
);
  // R9: an idle unit drives no bank read
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bank_re == '0));

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the cycle before done carries no read, the last data was returning
  a_r7_drain_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(bank_re == '0));

  // R4: reported cycle count lies between one and the lane count
  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles >= CW'(1) && cycles <= CW'(LANES)));

  // R8: an accepted request makes the unit busy on the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R8: done never coincides with busy
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind gs_gather_sched gs_gather_sched_chk #(
  .LANES(LANES), .NBANKS(NBANKS), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .bank_re  (bank_re),
  .done     (done),
  .cycles   (cycles)
);

// File: tb/test_gs_gather_sched.sv
`timescale 1ns/1ps
module test_gs_gather_sched;
  localparam int LANES = 16;
  localparam int NB    = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int BW    = 2;
  localparam int RW    = AW - BW;
  localparam int CW    = 5;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                busy;
  logic [NB-1:0]       bank_re;
  logic [NB*RW-1:0]    bank_row;
  logic [NB*DW-1:0]    bank_rdata = '0;
  logic                done;
  logic [LANES*DW-1:0] result;
  logic [CW-1:0]       cycles;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  gs_gather_sched i_gs_gather_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .bank_re(bank_re), .bank_row(bank_row),
    .bank_rdata(bank_rdata), .done(done), .result(result), .cycles(cycles)
  );

  function automatic logic [DW-1:0] mdata(int a);
    return DW'((a * 40503) ^ 23130);
  endfunction

  // banked memory model, one cycle of read latency
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bank_re[b]) bank_rdata[b*DW +: DW] <= mdata(int'(bank_row[b*RW +: RW]) * NB + b);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int ea [LANES];
  int ex_re  [LANES+1][NB];
  int ex_row [LANES+1][NB];
  int ex_k;

  // behavioural reference: per-cycle buckets
  task automatic model();
    bit pend [LANES];
    int left = LANES;
    for (int i = 0; i < LANES; i++) pend[i] = 1'b1;
    ex_k = 0;
    while (left > 0) begin
      for (int b = 0; b < NB; b++) begin
        int w = -1;
        for (int i = 0; i < LANES; i++)
          if (w < 0 && pend[i] && (ea[i] % NB) == b) w = i;
        ex_re[ex_k][b]  = (w >= 0);
        ex_row[ex_k][b] = (w >= 0) ? ea[w] / NB : 0;
        if (w >= 0) begin
          int wa = ea[w];
          for (int i = 0; i < LANES; i++)
            if (pend[i] && ea[i] == wa) begin pend[i] = 1'b0; left--; end
        end
      end
      ex_k++;
    end
  endtask

  task automatic run(string tag, bit intrude);
    model();
    @(negedge clk);
    req_valid = 1'b1;
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = AW'(ea[i]);
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = AW'(255 - i);
    end else req_valid = 1'b0;
    for (int k = 0; k < ex_k; k++) begin
      chk(busy == 1'b1, "R8", {tag, " busy"}, busy, 1);
      chk(done == 1'b0, "R7", {tag, " early done"}, done, 0);
      for (int b = 0; b < NB; b++) begin
        chk(bank_re[b] == ex_re[k][b], "R2", {tag, " bank enable"}, bank_re[b], ex_re[k][b]);
        if (ex_re[k][b] != 0)
          chk(int'(bank_row[b*RW +: RW]) == ex_row[k][b], "R3", {tag, " bank row"},
              int'(bank_row[b*RW +: RW]), ex_row[k][b]);
      end
      @(negedge clk);
    end
    chk(bank_re == '0, "R6", {tag, " drain read"}, int'(bank_re), 0);
    chk(done == 1'b0, "R7", {tag, " drain done"}, done, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R7", {tag, " done"}, done, 1);
    chk(int'(cycles) == ex_k, "R4", {tag, " cycles"}, int'(cycles), ex_k);
    for (int i = 0; i < LANES; i++)
      chk(result[i*DW +: DW] == mdata(ea[i]), "R6", {tag, " lane data"},
          int'(result[i*DW +: DW]), int'(mdata(ea[i])));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " after done"}, int'({busy, done}), 0);
  endtask

  initial begin
    int seed = 7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(busy == 1'b0 && done == 1'b0, "R9", "reset flags", int'({busy, done}), 0);
    chk(bank_re == '0, "R9", "reset enables", int'(bank_re), 0);
    chk(cycles == '0 && result == '0, "R9", "reset outputs", int'(cycles), 0);

    // R2 R5: lanes cover all banks with repeats -> one cycle
    for (int i = 0; i < LANES; i++) ea[i] = 40 + (i % NB);
    run("spread", 1'b0);
    // R5: all lanes identical
    for (int i = 0; i < LANES; i++) ea[i] = 7;
    run("same", 1'b0);
    // R4: one bank, distinct rows -> sixteen cycles
    for (int i = 0; i < LANES; i++) ea[i] = i * NB;
    run("onebank", 1'b0);
    // R1 R3: linear and reversed
    for (int i = 0; i < LANES; i++) ea[i] = i;
    run("linear", 1'b0);
    for (int i = 0; i < LANES; i++) ea[i] = 255 - i;
    run("reverse", 1'b0);
    // R8: strobe held with other addresses throughout
    for (int i = 0; i < LANES; i++) ea[i] = (i * 5) % 32;
    run("intrude", 1'b1);
    // R3 R5: small pool, many duplicates
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < LANES; i++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        ea[i] = (t < 6) ? ((seed >> 8) % 12) : ((seed >> 8) % 256);
      end
      run("mixed", 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule